// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block controls one power supply rail. It turns the rail's enable on in an ordered way, supervises the rail voltage while it is regulating, and turns the enable off again. The turn-on path waits for the rail's turn-on dependencies, then waits a programmed start delay, then asserts enable and waits for the rail voltage to reach its power-good-on level. The turn-off path waits for the turn-off dependencies, then waits a programmed stop delay, then drops enable. After that it can watch the voltage fall to a power-good-off level. Every delay and timeout counts pulses of a shared millisecond strobe, `ms_tick`. Voltages arrive as unsigned 12-bit samples, and the block looks at a sample only in a cycle where `smp_vld` is high.

The block is in one of eight named states, and `state_code` reports which one:
- IDLE (1): the rail is off.
- SEQ_ON (2): waiting for the turn-on dependencies.
- START_DELAY (3): counting the start delay.
- RAMP_UP (4): enable is high and the block waits for power-good-on.
- REGULATION (5): the rail is supervised.
- SEQ_OFF (6): waiting for the turn-off dependencies.
- STOP_DELAY (7): counting the stop delay.
- RAMP_DOWN (8): enable is low and the block waits for power-good-off.

The transitions are:
- IDLE→SEQ_ON: on request.
- SEQ_ON→START_DELAY: dependencies met.
- START_DELAY→RAMP_UP: delay elapsed.
- RAMP_UP→REGULATION: power-good-on reached.
- RAMP_UP or REGULATION→SEQ_OFF: off request.
- SEQ_ON or START_DELAY→IDLE: request withdrawn.
- SEQ_OFF→STOP_DELAY: turn-off dependencies met.
- STOP_DELAY→RAMP_DOWN, IDLE or SEQ_ON: enable released, or a retry.
- RAMP_DOWN→IDLE: power-good-off reached or timeout.
- Fault transitions: into STOP_DELAY, RAMP_DOWN or IDLE.

A fault is a sample outside the fault limits while in REGULATION, or a turn-on timeout. Each fault is handled by the selected response. When the rail faults, it sends a one-cycle shutdown request to a configurable set of dependent rails. A shutdown request arriving from another rail shuts this rail down and parks it until a group resequence release.

Top module: `rail_seq_ctrl`

## Requirements
- R1: `state_code` encodes IDLE=1, SEQ_ON=2, START_DELAY=3, RAMP_UP=4, REGULATION=5, SEQ_OFF=6, STOP_DELAY=7, RAMP_DOWN=8. After reset the block is in IDLE with every output flag low and `rail_en` low.
- R2: IDLE moves to SEQ_ON only when `on_req` is high, `flt_latched` is low, and either no resequence is pending or `reseq_go` is high. A latched fault keeps the rail in IDLE until `flt_clr`.
- R3: SEQ_ON holds until `dep_on_ok` is high. START_DELAY then lasts until `ton_dly` ticks have been counted. `rail_en` stays low in both states. Dropping `on_req` in either state returns the block to IDLE.
- R4: In RAMP_UP `rail_en` is high. The block enters REGULATION on a valid sample that is at or above `thr_pg_on`. When `thr_pg_on` is 0 it never leaves RAMP_UP this way, whatever the samples are.
- R5: REGULATION holds even when a sample falls below `thr_pg_on`. It is left only on a fault, on an off request, or on `ext_shut`.
- R6: In REGULATION each valid sample updates the warning flags: `uv_warn` is set when the sample is below `thr_uv_warn`, and `ov_warn` when it is above `thr_ov_warn`. Both warnings are low outside REGULATION. A sample below `thr_uv_flt` sets `uv_flt`, and one above `thr_ov_flt` sets `ov_flt`. Both fault flags stay set until `flt_clr`.
- R7: Dropping `on_req` in RAMP_UP or REGULATION moves the block to SEQ_OFF. SEQ_OFF waits for `dep_off_ok`. STOP_DELAY then lasts `toff_dly` ticks. `rail_en` stays high through both states.
- R8: When enable is released, the block enters RAMP_DOWN if `toff_max` is non-zero and the release is not a restart retry. Otherwise it goes to IDLE, or to SEQ_ON for a retry. RAMP_DOWN exits to IDLE on a valid sample at or below `thr_pg_off`.
- R9: `toff_max` = 0 and `ton_max` = 0 both mean unlimited. When RAMP_UP lasts `ton_max` ticks, `ton_timeout` is set and the event is handled as a fault. When RAMP_DOWN lasts `toff_max` ticks, `toff_timeout` is set and the block goes to IDLE.
- R10: `flt_resp` selects the fault response: 0 = restart, 1 = immediate shutdown, 2 = sequenced off, 3 = shutdown and resequence.
  - Immediate shutdown releases enable at once and latches the fault.
  - Sequenced off goes straight to STOP_DELAY, skipping the dependency wait, and latches the fault.
  - Resequence releases enable at once and waits in IDLE for `reseq_go`.
- R11: The restart response goes to STOP_DELAY. When the delay ends it returns to SEQ_ON while fewer than `retry_lim` retries have been used. Once the retries are used up it latches the fault. The retry count returns to zero on `flt_clr` and on every fresh turn-on from IDLE.
- R12: Each fault of this rail drives `shut_out` = `shut_mask` for exactly one cycle. `ext_shut` in any state from SEQ_ON to STOP_DELAY shuts the rail down, leaves `shut_out` low, and sets a pending resequence.
- R13: `flt_clr` clears `flt_latched`, `uv_flt`, `ov_flt`, `ton_timeout`, `toff_timeout` and the retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | Millisecond strobe for delays and timeouts |
| on_req | input | 1 | Rail on request (low = off request) |
| dep_on_ok | input | 1 | Turn-on dependencies satisfied |
| dep_off_ok | input | 1 | Turn-off dependencies satisfied |
| ext_shut | input | 1 | Fault shutdown request from another rail |
| reseq_go | input | 1 | Group resequence release |
| flt_clr | input | 1 | Clear latched fault state and flags |
| smp_vld | input | 1 | Voltage sample valid |
| smp_val | input | SMP_W | Voltage sample, unsigned |
| thr_pg_on | input | SMP_W | Power-good-on level (0 disables) |
| thr_pg_off | input | SMP_W | Power-good-off level |
| thr_uv_warn | input | SMP_W | Undervoltage warning limit |
| thr_uv_flt | input | SMP_W | Undervoltage fault limit |
| thr_ov_warn | input | SMP_W | Overvoltage warning limit |
| thr_ov_flt | input | SMP_W | Overvoltage fault limit |
| ton_dly | input | TIME_W | Start delay in ticks |
| toff_dly | input | TIME_W | Stop delay in ticks |
| ton_max | input | TIME_W | Turn-on time limit in ticks, 0 = unlimited |
| toff_max | input | TIME_W | Turn-off time limit in ticks, 0 = unlimited |
| flt_resp | input | 2 | Fault response select |
| retry_lim | input | RETRY_W | Restart retries allowed |
| shut_mask | input | N_DEP | Rails to shut down on a fault |
| rail_en | output | 1 | Rail enable |
| uv_warn | output | 1 | Undervoltage warning |
| uv_flt | output | 1 | Undervoltage fault, sticky |
| ov_warn | output | 1 | Overvoltage warning |
| ov_flt | output | 1 | Overvoltage fault, sticky |
| ton_timeout | output | 1 | Turn-on time limit exceeded, sticky |
| toff_timeout | output | 1 | Turn-off time limit exceeded, sticky |
| flt_latched | output | 1 | Fault latched, rail held off |
| shut_out | output | N_DEP | Shutdown request pulse to dependent rails |
| state_code | output | 4 | Current state code |

## Verification
The timing of every result is fixed:
- State changes, `rail_en` changes, and flag and `shut_out` updates all appear one clock edge after the input that causes them.
- A delay or timeout of N ticks ends one edge after the Nth `ms_tick` pulse has been counted.
- `shut_out` is high only in the cycle right after the fault edge.

The bench drives every input on the falling clock edge and samples on the next falling edge. Each task therefore advances exactly the number of edges that a transition needs before it compares. It also checks the state one tick before a delay ends, to show that the delay is not cut short.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd1,
        ST_SEQ_ON    = 4'd2,
        ST_START_DLY = 4'd3,
        ST_RAMP_UP   = 4'd4,
        ST_REGUL     = 4'd5,
        ST_SEQ_OFF   = 4'd6,
        ST_STOP_DLY  = 4'd7,
        ST_RAMP_DN   = 4'd8
    } rail_st_e;

    typedef enum logic [1:0] {
        RESP_RESTART  = 2'd0,
        RESP_KILL     = 2'd1,
        RESP_SOFT_OFF = 2'd2,
        RESP_RESEQ    = 2'd3
    } flt_resp_e;

    typedef struct packed {
        logic uv_warn;
        logic uv_flt;
        logic ov_warn;
        logic ov_flt;
        logic pg_on_hit;
        logic pg_off_hit;
    } volt_cmp_t;

endpackage

// File: rtl/rail_volt_cmp.sv
module rail_volt_cmp
    import rail_seq_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic [SMP_W-1:0] smp_val,
    input  logic [SMP_W-1:0] thr_pg_on,
    input  logic [SMP_W-1:0] thr_pg_off,
    input  logic [SMP_W-1:0] thr_uv_warn,
    input  logic [SMP_W-1:0] thr_uv_flt,
    input  logic [SMP_W-1:0] thr_ov_warn,
    input  logic [SMP_W-1:0] thr_ov_flt,
    output volt_cmp_t        cmp
);

    always_comb begin
        cmp.uv_warn    = smp_val < thr_uv_warn;
        cmp.uv_flt     = smp_val < thr_uv_flt;
        cmp.ov_warn    = smp_val > thr_ov_warn;
        cmp.ov_flt     = smp_val > thr_ov_flt;
        // a zero power-good-on level can never be reached
        cmp.pg_on_hit  = (thr_pg_on != '0) && (smp_val >= thr_pg_on);
        cmp.pg_off_hit = smp_val <= thr_pg_off;
    end

endmodule

// File: rtl/rail_tick_timer.sv
module rail_tick_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    output logic [TIME_W-1:0] cnt
);

    localparam logic [TIME_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt != CNT_TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int TIME_W  = 16,
    parameter int RETRY_W = 3,
    parameter int N_DEP   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               on_req,
    input  logic               dep_on_ok,
    input  logic               dep_off_ok,
    input  logic               ext_shut,
    input  logic               reseq_go,
    input  logic               flt_clr,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   smp_val,
    input  logic [SMP_W-1:0]   thr_pg_on,
    input  logic [SMP_W-1:0]   thr_pg_off,
    input  logic [SMP_W-1:0]   thr_uv_warn,
    input  logic [SMP_W-1:0]   thr_uv_flt,
    input  logic [SMP_W-1:0]   thr_ov_warn,
    input  logic [SMP_W-1:0]   thr_ov_flt,
    input  logic [TIME_W-1:0]  ton_dly,
    input  logic [TIME_W-1:0]  toff_dly,
    input  logic [TIME_W-1:0]  ton_max,
    input  logic [TIME_W-1:0]  toff_max,
    input  logic [1:0]         flt_resp,
    input  logic [RETRY_W-1:0] retry_lim,
    input  logic [N_DEP-1:0]   shut_mask,
    output logic               rail_en,
    output logic               uv_warn,
    output logic               uv_flt,
    output logic               ov_warn,
    output logic               ov_flt,
    output logic               ton_timeout,
    output logic               toff_timeout,
    output logic               flt_latched,
    output logic [N_DEP-1:0]   shut_out,
    output logic [3:0]         state_code
);

    localparam logic [TIME_W-1:0] UNLIMITED = '0;

    rail_st_e            st, nxt;
    flt_resp_e           resp;
    volt_cmp_t           cmp;
    logic [TIME_W-1:0]   cnt;
    logic                tmr_clr;
    logic                reseq_pend;
    logic                restart_pend;
    logic [RETRY_W-1:0]  retry_used;

    logic                enabled, seq_active;
    logic                on_dly_done, off_dly_done;
    logic                ton_expired, toff_expired;
    logic                ramp_ok, fall_ok;
    logic                reg_flt, ramp_flt, own_flt;
    logic                retry_left;
    rail_st_e            off_dst;

    assign resp = flt_resp_e'(flt_resp);

    rail_volt_cmp #(.SMP_W(SMP_W)) u_cmp (
        .smp_val     (smp_val),
        .thr_pg_on   (thr_pg_on),
        .thr_pg_off  (thr_pg_off),
        .thr_uv_warn (thr_uv_warn),
        .thr_uv_flt  (thr_uv_flt),
        .thr_ov_warn (thr_ov_warn),
        .thr_ov_flt  (thr_ov_flt),
        .cmp         (cmp)
    );

    // one timer serves every state: it restarts on each state change
    assign tmr_clr = (nxt != st);

    rail_tick_timer #(.TIME_W(TIME_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (ms_tick),
        .cnt   (cnt)
    );

    // derived conditions
    always_comb begin
        enabled      = (st == ST_RAMP_UP) || (st == ST_REGUL) ||
                       (st == ST_SEQ_OFF) || (st == ST_STOP_DLY);
        seq_active   = enabled || (st == ST_SEQ_ON) || (st == ST_START_DLY);
        on_dly_done  = cnt >= ton_dly;
        off_dly_done = cnt >= toff_dly;
        ton_expired  = (ton_max != UNLIMITED) && (cnt >= ton_max);
        toff_expired = (toff_max != UNLIMITED) && (cnt >= toff_max);
        ramp_ok      = smp_vld && cmp.pg_on_hit;
        fall_ok      = smp_vld && cmp.pg_off_hit;
        reg_flt      = (st == ST_REGUL) && smp_vld && (cmp.uv_flt || cmp.ov_flt);
        ramp_flt     = (st == ST_RAMP_UP) && on_req && !ramp_ok && ton_expired;
        own_flt      = (reg_flt || ramp_flt) && !ext_shut;
        retry_left   = retry_used < retry_lim;
        off_dst      = (toff_max != UNLIMITED) ? ST_RAMP_DN : ST_IDLE;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (on_req && !flt_latched && (!reseq_pend || reseq_go))
                    nxt = ST_SEQ_ON;
            end
            ST_SEQ_ON: begin
                if (!on_req)        nxt = ST_IDLE;
                else if (dep_on_ok) nxt = ST_START_DLY;
            end
            ST_START_DLY: begin
                if (!on_req)          nxt = ST_IDLE;
                else if (on_dly_done) nxt = ST_RAMP_UP;
            end
            ST_RAMP_UP: begin
                if (!on_req)      nxt = ST_SEQ_OFF;
                else if (ramp_ok) nxt = ST_REGUL;
            end
            ST_REGUL: begin
                if (!on_req) nxt = ST_SEQ_OFF;
            end
            ST_SEQ_OFF: begin
                if (dep_off_ok) nxt = ST_STOP_DLY;
            end
            ST_STOP_DLY: begin
                if (off_dly_done) begin
                    if (restart_pend && retry_left) nxt = ST_SEQ_ON;
                    else                            nxt = off_dst;
                end
            end
            ST_RAMP_DN: begin
                if (fall_ok || toff_expired) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase

        if (own_flt) begin
            unique case (resp)
                RESP_RESTART,
                RESP_SOFT_OFF: nxt = ST_STOP_DLY;
                RESP_KILL,
                RESP_RESEQ:    nxt = off_dst;
                default:       nxt = off_dst;
            endcase
        end

        if (ext_shut && seq_active)
            nxt = enabled ? off_dst : ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // registered flags and fault bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_warn      <= 1'b0;
            ov_warn      <= 1'b0;
            uv_flt       <= 1'b0;
            ov_flt       <= 1'b0;
            ton_timeout  <= 1'b0;
            toff_timeout <= 1'b0;
            flt_latched  <= 1'b0;
            reseq_pend   <= 1'b0;
            restart_pend <= 1'b0;
            retry_used   <= '0;
            shut_out     <= '0;
        end else begin
            shut_out <= own_flt ? shut_mask : '0;

            if (st == ST_REGUL) begin
                if (smp_vld) begin
                    uv_warn <= cmp.uv_warn;
                    ov_warn <= cmp.ov_warn;
                end
            end else begin
                uv_warn <= 1'b0;
                ov_warn <= 1'b0;
            end

            if (own_flt && reg_flt) begin
                if (cmp.uv_flt) uv_flt <= 1'b1;
                if (cmp.ov_flt) ov_flt <= 1'b1;
            end
            if (own_flt && ramp_flt)
                ton_timeout <= 1'b1;
            if ((st == ST_RAMP_DN) && toff_expired && !fall_ok)
                toff_timeout <= 1'b1;

            if (own_flt) begin
                unique case (resp)
                    RESP_RESTART:  restart_pend <= 1'b1;
                    RESP_KILL,
                    RESP_SOFT_OFF: flt_latched  <= 1'b1;
                    RESP_RESEQ:    reseq_pend   <= 1'b1;
                    default:       flt_latched  <= 1'b1;
                endcase
            end

            if ((st == ST_STOP_DLY) && off_dly_done && restart_pend && !ext_shut) begin
                restart_pend <= 1'b0;
                if (retry_left) retry_used  <= retry_used + 1'b1;
                else            flt_latched <= 1'b1;
            end

            if (ext_shut && seq_active) begin
                reseq_pend   <= 1'b1;
                restart_pend <= 1'b0;
            end

            if ((st == ST_IDLE) && reseq_go)
                reseq_pend <= 1'b0;
            if ((st == ST_IDLE) && (nxt == ST_SEQ_ON))
                retry_used <= '0;

            if (flt_clr) begin
                flt_latched  <= 1'b0;
                uv_flt       <= 1'b0;
                ov_flt       <= 1'b0;
                ton_timeout  <= 1'b0;
                toff_timeout <= 1'b0;
                retry_used   <= '0;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rail_en    = enabled;
        state_code = st;
    end

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
    parameter int SMP_W  = 12,
    parameter int TIME_W = 16,
    parameter int N_DEP  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              on_req,
    input logic              dep_on_ok,
    input logic              dep_off_ok,
    input logic              ext_shut,
    input logic              smp_vld,
    input logic [SMP_W-1:0]  smp_val,
    input logic [SMP_W-1:0]  thr_pg_on,
    input logic [SMP_W-1:0]  thr_uv_flt,
    input logic [SMP_W-1:0]  thr_ov_flt,
    input logic [TIME_W-1:0] ton_max,
    input logic              flt_latched,
    input logic [N_DEP-1:0]  shut_out,
    input logic [3:0]        state_code
);

    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code >= 4'd1) && (state_code <= 4'd8));

    a_r2_latched_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd1) && flt_latched |=> state_code == 4'd1);

    a_r3_seq_on_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd2) && on_req && !dep_on_ok && !ext_shut |=> state_code == 4'd2);

    a_r4_zero_pg_holds_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd4) && (thr_pg_on == '0) && (ton_max == '0) && on_req && !ext_shut
        |=> state_code == 4'd4);

    a_r5_regulation_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd5) && on_req && !ext_shut &&
        !(smp_vld && ((smp_val < thr_uv_flt) || (smp_val > thr_ov_flt)))
        |=> state_code == 4'd5);

    a_r7_seq_off_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd6) && !dep_off_ok && !ext_shut |=> state_code == 4'd6);

    a_r12_shut_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_out != '0) |=> (shut_out == '0));

endmodule

bind rail_seq_ctrl rail_seq_chk #(
    .SMP_W  (SMP_W),
    .TIME_W (TIME_W),
    .N_DEP  (N_DEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_req      (on_req),
    .dep_on_ok   (dep_on_ok),
    .dep_off_ok  (dep_off_ok),
    .ext_shut    (ext_shut),
    .smp_vld     (smp_vld),
    .smp_val     (smp_val),
    .thr_pg_on   (thr_pg_on),
    .thr_uv_flt  (thr_uv_flt),
    .thr_ov_flt  (thr_ov_flt),
    .ton_max     (ton_max),
    .flt_latched (flt_latched),
    .shut_out    (shut_out),
    .state_code  (state_code)
);

// File: tb/rail_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb;

    localparam int SMP_W = 12, TIME_W = 16, RETRY_W = 3, N_DEP = 4;
    localparam logic [N_DEP-1:0] MASK = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 0, on_req = 0, dep_on_ok = 0, dep_off_ok = 0;
    logic ext_shut = 0, reseq_go = 0, flt_clr = 0, smp_vld = 0;
    logic [SMP_W-1:0] smp_val = '0;
    logic [SMP_W-1:0] thr_pg_on = 12'd950, thr_pg_off = 12'd200;
    logic [SMP_W-1:0] thr_uv_warn = 12'd900, thr_uv_flt = 12'd800;
    logic [SMP_W-1:0] thr_ov_warn = 12'd1100, thr_ov_flt = 12'd1200;
    logic [TIME_W-1:0] ton_dly = '0, toff_dly = '0, ton_max = '0, toff_max = '0;
    logic [1:0] flt_resp = 2'd1;
    logic [RETRY_W-1:0] retry_lim = '0;
    logic [N_DEP-1:0] shut_mask = MASK;
    logic rail_en, uv_warn, uv_flt, ov_warn, ov_flt, ton_timeout, toff_timeout, flt_latched;
    logic [N_DEP-1:0] shut_out;
    logic [3:0] state_code;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rail_seq_ctrl #(.SMP_W(SMP_W), .TIME_W(TIME_W), .RETRY_W(RETRY_W), .N_DEP(N_DEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .on_req(on_req),
        .dep_on_ok(dep_on_ok), .dep_off_ok(dep_off_ok), .ext_shut(ext_shut),
        .reseq_go(reseq_go), .flt_clr(flt_clr), .smp_vld(smp_vld), .smp_val(smp_val),
        .thr_pg_on(thr_pg_on), .thr_pg_off(thr_pg_off), .thr_uv_warn(thr_uv_warn),
        .thr_uv_flt(thr_uv_flt), .thr_ov_warn(thr_ov_warn), .thr_ov_flt(thr_ov_flt),
        .ton_dly(ton_dly), .toff_dly(toff_dly), .ton_max(ton_max), .toff_max(toff_max),
        .flt_resp(flt_resp), .retry_lim(retry_lim), .shut_mask(shut_mask),
        .rail_en(rail_en), .uv_warn(uv_warn), .uv_flt(uv_flt), .ov_warn(ov_warn),
        .ov_flt(ov_flt), .ton_timeout(ton_timeout), .toff_timeout(toff_timeout),
        .flt_latched(flt_latched), .shut_out(shut_out), .state_code(state_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1; step(1); ms_tick = 1'b0;
    endtask

    task automatic sample(input int v);
        smp_val = v[SMP_W-1:0]; smp_vld = 1'b1; step(1); smp_vld = 1'b0;
    endtask

    task automatic clear_all();
        on_req = 1'b0; flt_clr = 1'b1; step(1); flt_clr = 1'b0; step(1);
    endtask

    task automatic bring_up();
        ton_dly = '0; dep_on_ok = 1'b1; on_req = 1'b1;
        step(1); chk("R2 idle to seq_on", state_code, 2);
        step(1); chk("R3 start delay", state_code, 3);
        step(1); chk("R4 ramp up", state_code, 4);
        sample(1000); chk("R4 regulation", state_code, 5);
    endtask

    task automatic t_reset();
        chk("R1 reset idle", state_code, 1);
        chk("R1 reset en", rail_en, 0);
        chk("R1 reset flags", {uv_warn, uv_flt, ov_warn, ov_flt, ton_timeout, toff_timeout, flt_latched}, 0);
    endtask

    task automatic t_turn_on();
        ton_dly = 16'd2; dep_on_ok = 1'b0; on_req = 1'b1;
        step(1); chk("R2 seq_on code", state_code, 2);
        step(2); chk("R3 waits for deps", state_code, 2);
        chk("R3 en low in seq_on", rail_en, 0);
        dep_on_ok = 1'b1; step(1); chk("R3 start_delay code", state_code, 3);
        tick(); tick(); chk("R3 delay not cut short", state_code, 3);
        chk("R3 en low in delay", rail_en, 0);
        step(1); chk("R4 ramp_up code", state_code, 4);
        chk("R4 en high", rail_en, 1);
        sample(900); chk("R4 below pg stays", state_code, 4);
        sample(960); chk("R4 to regulation", state_code, 5);
    endtask

    task automatic t_regulation();
        sample(850);
        chk("R5 sag holds regulation", state_code, 5);
        chk("R6 uv warn", uv_warn, 1);
        chk("R6 no uv fault", uv_flt, 0);
        sample(1150);
        chk("R6 ov warn", ov_warn, 1);
        chk("R6 uv warn follows sample", uv_warn, 0);
        sample(1000);
        chk("R6 warns clear", {uv_warn, ov_warn}, 0);
    endtask

    task automatic t_off_plain();
        toff_dly = 16'd1; toff_max = '0; dep_off_ok = 1'b0; on_req = 1'b0;
        step(1); chk("R7 seq_off code", state_code, 6);
        step(2); chk("R7 seq_off waits", state_code, 6);
        chk("R7 en high in seq_off", rail_en, 1);
        dep_off_ok = 1'b1; step(1); chk("R7 stop_delay code", state_code, 7);
        tick(); chk("R7 stop delay holds", state_code, 7);
        chk("R7 en high in stop delay", rail_en, 1);
        step(1); chk("R8 unlimited goes idle", state_code, 1);
        chk("R8 en low", rail_en, 0);
    endtask

    task automatic t_ramp_down();
        bring_up();
        toff_dly = '0; toff_max = 16'd5; dep_off_ok = 1'b1; on_req = 1'b0;
        step(3); chk("R8 ramp_down entered", state_code, 8);
        chk("R8 en low in ramp_down", rail_en, 0);
        sample(500); chk("R8 above pg_off holds", state_code, 8);
        sample(150); chk("R8 pg_off to idle", state_code, 1);
        chk("R9 no off timeout", toff_timeout, 0);
    endtask

    task automatic t_off_timeout();
        bring_up();
        toff_max = 16'd2; on_req = 1'b0;
        step(3); chk("R9 ramp_down", state_code, 8);
        tick(); tick(); chk("R9 before limit", state_code, 8);
        step(1); chk("R9 off timeout idle", state_code, 1);
        chk("R9 toff_timeout", toff_timeout, 1);
        clear_all(); chk("R13 clears toff_timeout", toff_timeout, 0);
        toff_max = '0;
    endtask

    task automatic t_ramp_stall();
        thr_pg_on = '0; ton_max = 16'd3; flt_resp = 2'd1; on_req = 1'b1; dep_on_ok = 1'b1;
        step(3); chk("R4 ramp_up zero pg", state_code, 4);
        sample(1000); chk("R4 zero pg never regulates", state_code, 4);
        tick(); tick(); tick(); chk("R9 before on limit", state_code, 4);
        step(1); chk("R9 on timeout kills", state_code, 1);
        chk("R9 ton_timeout", ton_timeout, 1);
        chk("R12 shut pulse on timeout", shut_out, MASK);
        step(1); chk("R12 pulse one cycle", shut_out, 0);
        chk("R2 latched holds idle", state_code, 1);
        clear_all();
        chk("R13 clears ton_timeout", ton_timeout, 0);
        chk("R13 clears latch", flt_latched, 0);
        thr_pg_on = 12'd950; ton_max = '0;
    endtask

    task automatic t_kill();
        flt_resp = 2'd1; toff_max = '0;
        bring_up();
        sample(1300);
        chk("R10 kill to idle", state_code, 1);
        chk("R10 kill en low", rail_en, 0);
        chk("R6 ov fault", ov_flt, 1);
        chk("R12 shut_out mask", shut_out, MASK);
        chk("R10 kill latches", flt_latched, 1);
        step(2); chk("R2 latched with on_req", state_code, 1);
        clear_all(); chk("R13 clears ov_flt", ov_flt, 0);
    endtask

    task automatic t_soft_off();
        flt_resp = 2'd2; toff_dly = 16'd1; toff_max = '0; dep_off_ok = 1'b0;
        bring_up();
        sample(700);
        chk("R10 soft off skips seq_off", state_code, 7);
        chk("R6 uv fault", uv_flt, 1);
        chk("R10 en kept in stop delay", rail_en, 1);
        tick(); chk("R10 stop delay holds", state_code, 7);
        step(1); chk("R10 soft off idle", state_code, 1);
        chk("R10 soft off latches", flt_latched, 1);
        clear_all(); dep_off_ok = 1'b1;
    endtask

    task automatic t_restart();
        flt_resp = 2'd0; retry_lim = 3'd1; toff_dly = '0; toff_max = 16'd5;
        bring_up();
        sample(1300); chk("R11 restart to stop delay", state_code, 7);
        chk("R12 shut on restart fault", shut_out, MASK);
        step(1); chk("R11 retry back to seq_on", state_code, 2);
        chk("R8 retry skips ramp_down", rail_en, 0);
        step(2); chk("R11 retry ramp", state_code, 4);
        sample(1000); chk("R11 retry regulates", state_code, 5);
        sample(1300); chk("R11 second fault", state_code, 7);
        step(1); chk("R11 exhausted ramp_down", state_code, 8);
        chk("R11 exhausted latches", flt_latched, 1);
        sample(100); chk("R8 ramp_down done", state_code, 1);
        step(2); chk("R11 latched stays idle", state_code, 1);
        clear_all(); toff_max = '0; retry_lim = '0;
    endtask

    task automatic t_reseq();
        flt_resp = 2'd3; toff_max = '0;
        bring_up();
        sample(1300); chk("R10 reseq shuts down", state_code, 1);
        chk("R10 reseq no latch", flt_latched, 0);
        step(3); chk("R2 waits resequence", state_code, 1);
        reseq_go = 1'b1; step(1); reseq_go = 1'b0;
        chk("R2 resequence release", state_code, 2);
        clear_all();
    endtask

    task automatic t_ext();
        flt_resp = 2'd1; toff_max = '0;
        bring_up();
        ext_shut = 1'b1; step(1); ext_shut = 1'b0;
        chk("R12 ext shut idle", state_code, 1);
        chk("R12 ext shut en low", rail_en, 0);
        chk("R12 ext no shut_out", shut_out, 0);
        step(2); chk("R12 ext waits reseq", state_code, 1);
        reseq_go = 1'b1; step(1); reseq_go = 1'b0;
        chk("R12 ext resequenced", state_code, 2);
        on_req = 1'b0; step(1); chk("R3 withdraw to idle", state_code, 1);
    endtask

    initial begin
        step(2); rst_n = 1'b1; step(1);
        t_reset();
        t_turn_on();
        t_regulation();
        t_off_plain();
        t_ramp_down();
        t_off_timeout();
        t_ramp_stall();
        t_kill();
        t_soft_off();
        t_restart();
        t_reseq();
        t_ext();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule